// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Read Timing

This block moves data words from a write clock domain to an unrelated read clock domain through a dual-ported register array. Each side keeps a binary pointer. The pointer also travels to the other side in Gray code through two flip-flops. Each side derives its own status from its own pointer and the synchronized copy of the far pointer.

The read timing is chosen while the master reset is held. In requested mode, a word only appears on the output after a read strobe. In fall-through mode, an extra output register fetches the oldest word on its own. That register adds one word of storage. The meaning and polarity of the two main status pins follow the chosen mode. Two threshold flags, with offsets that can be rewritten while the FIFO holds nothing, warn early of a nearly drained or a nearly filled FIFO.

The FIFO holds D = 2^AW words in the array. Its word count also includes the output register when that register is valid.

Top module: `dc_fifo_fwft`

## Requirements
- R1: The level of `mode_sel` at the write and read clock edges during master reset (`mrst_n` low) picks the timing: 0 = requested, 1 = fall-through. Later changes of `mode_sel` have no effect until the next reset.
- R2: Requested mode: `rd_data` is 0 after reset. It only changes on a `rd_clk` edge with `rd_en_n` low and a word stored, and then it takes the oldest unread word, in write order.
- R3: Fall-through mode: a word written into an empty FIFO is on `rd_data` after the third `rd_clk` rising edge that follows its write edge, with `rd_en_n` held high. Each further word appears after a read strobe takes the current one.
- R4: A word is stored on a `wr_clk` edge when `wr_en_n` is low and the FIFO is not full. A write attempted while full stores nothing and corrupts nothing.
- R5: Requested mode: `rd_flag` is 0 while no word is stored and 1 while at least one word is stored.
- R6: Requested mode: `wr_flag` is 0 when D words are stored and 1 otherwise. A read from a full FIFO returns it to 1.
- R7: Fall-through mode: `rd_flag` is 0 while a valid word sits on `rd_data`, and 1 after the last word has been taken.
- R8: Fall-through mode: `wr_flag` is 1 when D+1 words are held (array full plus output register) and 0 otherwise. A read returns it to 0.
- R9: `almost_empty_n` is 1 when the word count exceeds the empty offset n (requested mode) or exceeds n+1 (fall-through mode), and 0 otherwise.
- R10: `almost_full_n` is 0 when the free space is at most the full offset m, and 1 otherwise. The capacity is D in requested mode and D+1 in fall-through mode.
- R11: `rd_en_n` low has no effect while no word is available: `rd_data` holds its value and the read pointer does not move.
- R12: A `wr_clk` edge with `cfg_we` high loads `cfg_val` into the empty offset (`cfg_sel`=0) or into the full offset (`cfg_sel`=1). The load only takes place while the write side sees an empty array and no write is requested. Reset restores the parameter defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mrst_n | input | 1 | Master reset, active low, asynchronous assertion |
| mode_sel | input | 1 | Timing select sampled during reset |
| wr_clk | input | 1 | Write clock |
| wr_en_n | input | 1 | Write strobe, active low |
| wr_data | input | DW | Write word |
| cfg_we | input | 1 | Offset load strobe (write clock) |
| cfg_sel | input | 1 | 0 = empty offset, 1 = full offset |
| cfg_val | input | AW+1 | Offset value |
| wr_flag | output | 1 | Full flag (active low) or input-ready (high = full) |
| almost_full_n | output | 1 | Low when free space is at most m |
| rd_clk | input | 1 | Read clock |
| rd_en_n | input | 1 | Read strobe, active low |
| rd_data | output | DW | Read word |
| rd_flag | output | 1 | Empty flag (active low) or output-ready (low = valid) |
| almost_empty_n | output | 1 | Low when the count is at or below the empty threshold |

## Verification
The bench fills the FIFO to capacity in both modes, writes once more, then drains it and reads once more. A design that let the extra write through would overwrite the oldest slot, and a read would return the wrong word. A design that let the extra read through would change `rd_data` or wrap the pointer. It counts read-clock edges from a single write to the point where fall-through data appears, which exposes a missing or extra synchronizer stage. It flips `mode_sel` after each reset, so a design that followed the live pin would show the wrong flag polarities. It loads new offsets on an empty FIFO and then tries a load on a non-empty one, so an unguarded load would move the almost-empty threshold.

// File: rtl/dc_fifo_fwft.sv
`timescale 1ns/1ps
module dc_fifo_fwft #(
  parameter int DW     = 16,
  parameter int AW     = 4,
  parameter int AE_DEF = 2,
  parameter int AF_DEF = 2
) (
  input  logic          mrst_n,
  input  logic          mode_sel,
  input  logic          wr_clk,
  input  logic          wr_en_n,
  input  logic [DW-1:0] wr_data,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW:0]   cfg_val,
  output logic          wr_flag,
  output logic          almost_full_n,
  input  logic          rd_clk,
  input  logic          rd_en_n,
  output logic [DW-1:0] rd_data,
  output logic          rd_flag,
  output logic          almost_empty_n
);

  localparam int D  = 1 << AW;
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [D];

  // write side
  logic          mode_w;
  logic [PW-1:0] wbin, wgray, rq1, rq2;
  logic [PW-1:0] rgray;
  logic [AW:0]   ae_off, af_off;

  wire [PW-1:0] wcnt   = wbin - g2b(rq2);
  wire          wfull  = (wcnt == PW'(D));
  wire          wr_go  = !wr_en_n && !wfull;
  wire          w_idle = (wcnt == '0) && wr_en_n;

  always_ff @(posedge wr_clk)
    if (!mrst_n) mode_w <= mode_sel;

  always_ff @(posedge wr_clk or negedge mrst_n)
    if (!mrst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      rq1    <= '0;
      rq2    <= '0;
      ae_off <= (AW+1)'(AE_DEF);
      af_off <= (AW+1)'(AF_DEF);
    end else begin
      rq1 <= rgray;
      rq2 <= rq1;
      if (wr_go) begin
        wbin  <= wbin + 1'b1;
        wgray <= b2g(wbin + 1'b1);
      end
      if (cfg_we && w_idle) begin
        if (cfg_sel) af_off <= cfg_val;
        else         ae_off <= cfg_val;
      end
    end

  always_ff @(posedge wr_clk)
    if (wr_go) mem[wbin[AW-1:0]] <= wr_data;

  assign wr_flag       = mode_w ? wfull : !wfull;
  assign almost_full_n = (PW'(D) - wcnt) > af_off;

  // read side
  logic          mode_r, ov;
  logic [PW-1:0] rbin, wq1, wq2;

  wire [PW-1:0] rcnt      = g2b(wq2) - rbin;
  wire          mem_empty = (rcnt == '0);
  wire          rd_req    = !rd_en_n;
  wire          std_go    = !mode_r && rd_req && !mem_empty;
  wire          fw_take   = mode_r && ov && rd_req;
  wire          fw_pull   = mode_r && !mem_empty && (!ov || rd_req);
  wire          pop       = std_go || fw_pull;
  wire [PW-1:0] total     = rcnt + PW'(ov);

  always_ff @(posedge rd_clk)
    if (!mrst_n) mode_r <= mode_sel;

  always_ff @(posedge rd_clk or negedge mrst_n)
    if (!mrst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      wq1     <= '0;
      wq2     <= '0;
      ov      <= 1'b0;
      rd_data <= '0;
    end else begin
      wq1 <= wgray;
      wq2 <= wq1;
      if (pop) begin
        rd_data <= mem[rbin[AW-1:0]];
        rbin    <= rbin + 1'b1;
        rgray   <= b2g(rbin + 1'b1);
      end
      if (fw_pull)      ov <= 1'b1;
      else if (fw_take) ov <= 1'b0;
    end

  assign rd_flag        = mode_r ? !ov : !mem_empty;
  assign almost_empty_n = {1'b0, total} > ({1'b0, ae_off} + (PW+1)'(mode_r));

  // checks
  a_r4_no_overflow: assert property (@(posedge wr_clk) disable iff (!mrst_n)
    (!wr_en_n && wfull) |=> $stable(wbin));

  a_r10_wcount_bound: assert property (@(posedge wr_clk) disable iff (!mrst_n)
    wcnt <= PW'(D));

  a_r10_rcount_bound: assert property (@(posedge rd_clk) disable iff (!mrst_n)
    rcnt <= PW'(D));

  a_r11_read_ignored_empty: assert property (@(posedge rd_clk) disable iff (!mrst_n)
    (rd_req && mem_empty && !ov) |=> ($stable(rbin) && $stable(rd_data)));

  a_r7_head_held: assert property (@(posedge rd_clk) disable iff (!mrst_n)
    (mode_r && ov && !rd_req) |=> (ov && $stable(rd_data)));

  a_r1_mode_held_w: assert property (@(posedge wr_clk) disable iff (!mrst_n)
    mrst_n |=> $stable(mode_w));

  a_r1_mode_held_r: assert property (@(posedge rd_clk) disable iff (!mrst_n)
    mrst_n |=> $stable(mode_r));

endmodule

// File: tb/tb_dc_fifo_fwft.sv
`timescale 1ns/1ps
module tb_dc_fifo_fwft;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int D  = 1 << AW;
  localparam int NV = 38;

  // entry: [5] mode (1 = fall-through), [4] op (1 = read), [3:0] expected word count afterwards
  localparam logic [5:0] VEC [NV] = '{
    6'h01, 6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07, 6'h08, 6'h08,
    6'h17, 6'h16, 6'h15, 6'h14, 6'h13, 6'h12, 6'h11, 6'h10, 6'h10,
    6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27, 6'h28, 6'h29, 6'h29,
    6'h38, 6'h37, 6'h36, 6'h35, 6'h34, 6'h33, 6'h32, 6'h31, 6'h30, 6'h30
  };

  logic mrst_n = 1'b0, mode_sel = 1'b0;
  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_en_n = 1'b1, rd_en_n = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [AW:0] cfg_val = '0;
  logic wr_flag, almost_full_n, rd_flag, almost_empty_n;
  logic [DW-1:0] rd_data;

  int checks = 0, errors = 0;

  dc_fifo_fwft #(.DW(DW), .AW(AW), .AE_DEF(2), .AF_DEF(2)) dut (
    .mrst_n(mrst_n), .mode_sel(mode_sel),
    .wr_clk(wr_clk), .wr_en_n(wr_en_n), .wr_data(wr_data),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_val(cfg_val),
    .wr_flag(wr_flag), .almost_full_n(almost_full_n),
    .rd_clk(rd_clk), .rd_en_n(rd_en_n), .rd_data(rd_data),
    .rd_flag(rd_flag), .almost_empty_n(almost_empty_n)
  );

  always #5 wr_clk = ~wr_clk;
  initial begin
    #2.5;
    forever #5 rd_clk = ~rd_clk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic m);
    mrst_n   = 1'b0;
    mode_sel = m;
    repeat (4) @(negedge wr_clk);
    mrst_n = 1'b1;
    repeat (3) @(negedge wr_clk);
    mode_sel = !m;
    repeat (3) @(negedge rd_clk);
  endtask

  task automatic do_write(input logic [DW-1:0] v);
    @(negedge wr_clk);
    wr_data = v;
    wr_en_n = 1'b0;
    @(negedge wr_clk);
    wr_en_n = 1'b1;
  endtask

  task automatic do_read();
    @(negedge rd_clk);
    rd_en_n = 1'b0;
    @(negedge rd_clk);
    rd_en_n = 1'b1;
  endtask

  task automatic do_cfg(input logic s, input logic [AW:0] v);
    @(negedge wr_clk);
    cfg_we  = 1'b1;
    cfg_sel = s;
    cfg_val = v;
    @(negedge wr_clk);
    cfg_we = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
    @(negedge wr_clk);
  endtask

  task automatic chk_flags(input logic m, input int lvl);
    if (!m) begin
      chk("R5 empty flag", rd_flag, lvl > 0);
      chk("R6 full flag", wr_flag, lvl < D);
      chk("R9 almost-empty", almost_empty_n, lvl > 2);
      chk("R10 almost-full", almost_full_n, (D - lvl) > 2);
    end else begin
      chk("R7 output-ready", rd_flag, lvl == 0);
      chk("R8 input-ready", wr_flag, lvl == D + 1);
      chk("R9 almost-empty", almost_empty_n, lvl > 3);
      chk("R10 almost-full", almost_full_n, (D + 1 - lvl) > 2);
    end
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int level, nw, nr, edges;
    logic cur_mode;
    level = 0; nw = 0; nr = 0; cur_mode = 1'b0;

    // reset state, requested mode (R1 via flipped mode_sel after reset)
    do_reset(1'b0);
    chk("R2 reset data", rd_data, 0);
    chk_flags(1'b0, 0);

    // R2: a stored word is not presented without a read strobe
    do_write(8'h3C);
    settle();
    chk("R2 no read no data", rd_data, 0);
    chk("R5 not empty", rd_flag, 1);
    do_read();
    chk("R2 read data", rd_data, 8'h3C);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      logic m, op;
      int lvl;
      m   = VEC[i][5];
      op  = VEC[i][4];
      lvl = int'(VEC[i][3:0]);
      if (i == 0 || m != cur_mode) begin
        do_reset(m);
        cur_mode = m;
        level = 0; nw = 0; nr = 0;
        chk("R1 mode reset flags", rd_flag, m);
      end
      if (!op) begin
        do_write(8'hA0 + DW'(nw));
        if (lvl > level) nw++;
      end else begin
        do_read();
        if (lvl < level) begin
          if (!m) chk("R2 read order", rd_data, 8'hA0 + DW'(nr));
          nr++;
        end else begin
          chk("R11 ignored read", rd_data, 8'hA0 + DW'(nr - 1));
        end
      end
      level = lvl;
      settle();
      chk_flags(m, level);
      if (m && level > 0) chk("R3 head word", rd_data, 8'hA0 + DW'(nr));
      if (level == 0 && op) chk("R4 no overflow order", nr, m ? D + 1 : D);
    end

    // R3: fall-through latency of the first word
    do_reset(1'b1);
    @(negedge wr_clk);
    wr_data = 8'h55;
    wr_en_n = 1'b0;
    @(posedge wr_clk);
    #1 wr_en_n = 1'b1;
    edges = 0;
    while (rd_flag && edges < 10) begin
      @(posedge rd_clk);
      #1 edges++;
    end
    chk("R3 first word edges", edges, 3);
    chk("R3 first word data", rd_data, 8'h55);

    // R12: offset loading only while empty
    do_reset(1'b0);
    do_cfg(1'b0, 4);
    do_cfg(1'b1, 1);
    for (int k = 0; k < 4; k++) do_write(DW'(k));
    settle();
    chk("R12 empty offset loaded", almost_empty_n, 0);
    do_cfg(1'b0, 0);
    settle();
    chk("R12 load ignored when not empty", almost_empty_n, 0);
    do_write(8'h04);
    settle();
    chk("R12 threshold above new offset", almost_empty_n, 1);
    do_write(8'h05);
    settle();
    chk("R12 full offset loaded free 2", almost_full_n, 1);
    do_write(8'h06);
    settle();
    chk("R12 full offset loaded free 1", almost_full_n, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule